// File: doc/BRIEF.md
# Low-Battery Hibernate Gate

This block supervises a backup battery on behalf of a power controller. An analog comparator outside the block compares the battery against a reference. The block chooses that reference with a two-bit select output. The comparator's result arrives unsynchronised. The block synchronises it and filters out short glitches. It then records an accepted low-battery event in a sticky status bit. Through a mask, that bit can raise an interrupt.

The same accepted condition affects hibernation in two ways. When vetoing is enabled, a request to enter hibernation is refused while the battery is low. When wake-on-low is enabled, a device that is already hibernating receives a wake request once the battery drops. Software configures the block through a small write-only register port with three registers: control, mask and clear.

Top module: `lbat_hib_gate`

## Requirements
- R1: After reset, `lbat_raw`, `irq`, `hib_grant`, `wake_req` and `thresh_sel` are all 0.
- R2: A write to address 0 loads control. Bit 0 is the veto enable, bit 1 is the wake enable, and bits 3:2 are the threshold code. The threshold code drives `thresh_sel` from the next clock edge. Codes 0, 1, 2 and 3 select 1.9 V, 2.1 V, 2.3 V and 2.5 V.
- R3: `cmp_low` passes through two synchroniser flops. It is accepted only after the synchronised value has been high on 4 consecutive edges. When it rises before edge 1, `lbat_raw` is still 0 after edge 6 and is 1 after edge 7. A pulse of 3 cycles never sets `lbat_raw`.
- R4: `lbat_raw` is sticky. It is cleared by a write to address 2 with bit 0 set. Writing 0 in that bit has no effect. A clear loses to a low condition that is still accepted in the same cycle.
- R5: `irq` equals `lbat_raw` AND the mask bit (address 1, bit 0), registered one cycle later.
- R6: A rising edge of `hib_req` yields a single-cycle `hib_grant` on the next edge, however long the request is held.
- R7: No grant is issued while the veto enable is set and the low condition is accepted.
- R8: While `hib_active` is high, the wake enable is set and the low condition is accepted, `wake_req` rises on the next edge. It then holds, even if the battery recovers, until the edge after `hib_active` falls.
- R9: Writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| hib_req | input | 1 | Request to enter hibernation |
| hib_active | input | 1 | Device is hibernating |
| cmp_low | input | 1 | Asynchronous comparator output, high when the battery is below the threshold |
| thresh_sel | output | 2 | Threshold code sent to the comparator |
| lbat_raw | output | 1 | Sticky low-battery status |
| irq | output | 1 | Masked low-battery interrupt |
| hib_grant | output | 1 | Single-cycle hibernate grant |
| wake_req | output | 1 | Wake request while hibernating |

## Verification
A fault in the filter counter appears at `lbat_raw` as a set arriving one edge early or late relative to edge 7, or as a glitch being accepted. A stuck status or mask register shows on `irq` within two edges. A lost request-edge register shows up as repeated grants on the very next cycle. A wrong wake state shows up as `wake_req` surviving the fall of `hib_active` by more than one edge. The bench compares every output on every cycle against a bench-side model, so any of these faults is seen within the cycle it reaches a port.

// File: rtl/lbat_pkg.sv
package lbat_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd2;

  localparam int B_VETO = 0;
  localparam int B_WAKE = 1;
  localparam int B_SEL  = 2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             wake_en;
    logic             veto_en;
  } ctrl_t;

  // saturating run-length step for the glitch filter
  function automatic logic [7:0] run_step(logic [7:0] run, logic level, logic [7:0] limit);
    if (!level)             return 8'd0;
    else if (run == limit)  return run;
    else                    return run + 8'd1;
  endfunction

  // threshold in millivolts for a select code
  function automatic int unsigned sel_to_mv(logic [SEL_W-1:0] code);
    return 32'd1900 + 32'd200 * 32'(code);
  endfunction
endpackage

// File: rtl/lbat_sync_filter.sv
module lbat_sync_filter #(
  parameter int STAGES   = 2,
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_o,
  output logic det_o
);
  import lbat_pkg::*;
  localparam logic [7:0] LIMIT = 8'(FILT_LEN);

  logic [STAGES-1:0] sh_q;
  logic [7:0]        run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      run_q <= '0;
    end else begin
      sh_q  <= {sh_q[STAGES-2:0], async_in};
      run_q <= run_step(run_q, sh_q[STAGES-1], LIMIT);
    end
  end

  assign sync_o = sh_q[STAGES-1];
  assign det_o  = (run_q == LIMIT);
endmodule

// File: rtl/lbat_cfg_regs.sv
module lbat_cfg_regs
  import lbat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic              mask_o,
  output logic              clr_o
);
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:B_SEL+SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
      mask_o <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          ctrl_o.veto_en <= wr_data[B_VETO];
          ctrl_o.wake_en <= wr_data[B_WAKE];
          ctrl_o.sel     <= wr_data[B_SEL +: SEL_W];
        end
        A_MASK:  mask_o <= wr_data[0];
        default: ;
      endcase
    end
  end

  assign clr_o = wr_en && (wr_addr == A_CLR) && wr_data[0];
endmodule

// File: rtl/lbat_status.sv
module lbat_status (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic clr,
  input  logic mask,
  output logic raw_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      raw_o <= det || (raw_o && !clr);
      irq_o <= raw_o && mask;
    end
  end
endmodule

// File: rtl/lbat_hib_ctl.sv
module lbat_hib_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic veto_en,
  input  logic wake_en,
  input  logic hib_req,
  input  logic hib_active,
  output logic req_rise_o,
  output logic grant_o,
  output logic wake_o
);
  logic req_q;

  assign req_rise_o = hib_req && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      grant_o <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      req_q   <= hib_req;
      grant_o <= req_rise_o && !(veto_en && det);
      if (!hib_active)          wake_o <= 1'b0;
      else if (wake_en && det)  wake_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lbat_hib_gate.sv
module lbat_hib_gate
  import lbat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hib_req,
  input  logic              hib_active,
  input  logic              cmp_low,
  output logic [SEL_W-1:0]  thresh_sel,
  output logic              lbat_raw,
  output logic              irq,
  output logic              hib_grant,
  output logic              wake_req
);
  logic  sync_s, low_det, clr_hit, irq_mask, req_rise;
  ctrl_t ctrl;

  lbat_sync_filter #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .async_in(cmp_low), .sync_o(sync_s), .det_o(low_det)
  );

  lbat_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_o(ctrl), .mask_o(irq_mask), .clr_o(clr_hit)
  );

  lbat_status u_stat (
    .clk(clk), .rst_n(rst_n), .det(low_det), .clr(clr_hit), .mask(irq_mask),
    .raw_o(lbat_raw), .irq_o(irq)
  );

  lbat_hib_ctl u_hib (
    .clk(clk), .rst_n(rst_n), .det(low_det), .veto_en(ctrl.veto_en), .wake_en(ctrl.wake_en),
    .hib_req(hib_req), .hib_active(hib_active), .req_rise_o(req_rise),
    .grant_o(hib_grant), .wake_o(wake_req)
  );

  assign thresh_sel = ctrl.sel;
endmodule

// File: rtl/lbat_hib_gate_chk.sv
module lbat_hib_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       sync_s,
  input logic       low_det,
  input logic       clr_hit,
  input logic       irq_mask,
  input logic       req_rise,
  input logic       veto_en,
  input logic       wake_en,
  input logic       hib_active,
  input logic [1:0] thresh_sel,
  input logic       lbat_raw,
  input logic       irq,
  input logic       hib_grant,
  input logic       wake_req
);
  a_r2_sel_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thresh_sel) |-> $past(wr_en && wr_addr == 2'd0));
  a_r3_det_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_det) |-> $past(sync_s));
  a_r4_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lbat_raw && !clr_hit |=> lbat_raw);
  a_r4_raw_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lbat_raw) |-> $past(low_det));
  a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(lbat_raw && irq_mask));
  a_r6_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    hib_grant |=> !hib_grant);
  a_r6_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    hib_grant |-> $past(req_rise));
  a_r7_no_grant_on_veto: assert property (@(posedge clk) disable iff (!rst_n)
    hib_grant |-> !$past(veto_en && low_det));
  a_r8_wake_release: assert property (@(posedge clk) disable iff (!rst_n)
    !hib_active |=> !wake_req);
  a_r8_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(hib_active && wake_en && low_det));
endmodule

bind lbat_hib_gate lbat_hib_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .sync_s(sync_s),
  .low_det(low_det), .clr_hit(clr_hit), .irq_mask(irq_mask), .req_rise(req_rise),
  .veto_en(ctrl.veto_en), .wake_en(ctrl.wake_en), .hib_active(hib_active),
  .thresh_sel(thresh_sel), .lbat_raw(lbat_raw), .irq(irq), .hib_grant(hib_grant),
  .wake_req(wake_req)
);

// File: tb/tb_lbat_hib_gate.sv
`timescale 1ns/1ps
module tb_lbat_hib_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       hib_req = 1'b0, hib_active = 1'b0, cmp_low = 1'b0;
  logic [1:0] thresh_sel;
  logic       lbat_raw, irq, hib_grant, wake_req;

  int n_chk = 0, n_bad = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  lbat_hib_gate dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hib_req(hib_req), .hib_active(hib_active), .cmp_low(cmp_low),
    .thresh_sel(thresh_sel), .lbat_raw(lbat_raw), .irq(irq),
    .hib_grant(hib_grant), .wake_req(wake_req)
  );

  // bench-side model, written from the requirements
  logic m_s1, m_s2, m_raw, m_irq, m_grant, m_wake, m_reqd, m_veto, m_wken, m_mask;
  logic [1:0] m_sel;
  int m_run;

  function automatic bit f_accepted(int run);
    return run >= 4;
  endfunction

  function automatic int f_run(int run, bit lvl);
    return !lvl ? 0 : (run >= 4 ? 4 : run + 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_run <= 0; m_raw <= 0; m_irq <= 0; m_grant <= 0;
      m_wake <= 0; m_reqd <= 0; m_veto <= 0; m_wken <= 0; m_mask <= 0; m_sel <= 0;
    end else begin
      m_s1 <= cmp_low;
      m_s2 <= m_s1;
      m_run <= f_run(m_run, m_s2);
      m_raw <= f_accepted(m_run) || (m_raw && !(wr_en && wr_addr == 2'd2 && wr_data[0]));
      m_irq <= m_raw && m_mask;
      m_reqd <= hib_req;
      m_grant <= hib_req && !m_reqd && !(m_veto && f_accepted(m_run));
      m_wake <= hib_active && (m_wake || (m_wken && f_accepted(m_run)));
      if (wr_en && wr_addr == 2'd0) begin
        m_veto <= wr_data[0]; m_wken <= wr_data[1]; m_sel <= wr_data[3:2];
      end
      if (wr_en && wr_addr == 2'd1) m_mask <= wr_data[0];
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) if (live) begin
    chk(thresh_sel == m_sel, "R2 thresh_sel", thresh_sel, m_sel);
    chk(lbat_raw == m_raw, "R3/R4 lbat_raw", lbat_raw, m_raw);
    chk(irq == m_irq, "R5 irq", irq, m_irq);
    chk(hib_grant == m_grant, "R6/R7 hib_grant", hib_grant, m_grant);
    chk(wake_req == m_wake, "R8 wake_req", wake_req, m_wake);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(4ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk({thresh_sel, lbat_raw, irq, hib_grant, wake_req} == 6'd0, "R1 reset",
        {thresh_sel, lbat_raw, irq, hib_grant, wake_req}, 0);
    live = 1;

    // R2 threshold code 2 (2.3 V)
    wr(2'd0, 8'b0000_1000);
    chk(thresh_sel == 2'd2, "R2 sel", thresh_sel, 2);
    // R9 address 3 ignored
    wr(2'd3, 8'hFF);
    tick(1);
    chk(thresh_sel == 2'd2, "R9 addr3 ignored", thresh_sel, 2);

    // R3 glitch of 3 cycles
    cmp_low = 1; tick(3); cmp_low = 0; tick(10);
    chk(lbat_raw == 0, "R3 glitch rejected", lbat_raw, 0);

    // R3 exact latency
    cmp_low = 1; tick(6);
    chk(lbat_raw == 0, "R3 edge6", lbat_raw, 0);
    tick(1);
    chk(lbat_raw == 1, "R3 edge7", lbat_raw, 1);

    // R5 masked off, then on
    tick(2);
    chk(irq == 0, "R5 masked", irq, 0);
    wr(2'd1, 8'h01); tick(1);
    chk(irq == 1, "R5 unmasked", irq, 1);

    // R4 clear loses to present condition
    wr(2'd2, 8'h01);
    chk(lbat_raw == 1, "R4 clear while low", lbat_raw, 1);
    cmp_low = 0; tick(4);
    wr(2'd2, 8'h00);
    chk(lbat_raw == 1, "R4 write 0 no effect", lbat_raw, 1);
    wr(2'd2, 8'h01);
    chk(lbat_raw == 0, "R4 cleared", lbat_raw, 0);
    tick(1);
    chk(irq == 0, "R5 irq follows clear", irq, 0);

    // R6 held request, single grant
    hib_req = 1; tick(1);
    chk(hib_grant == 1, "R6 grant", hib_grant, 1);
    tick(1);
    chk(hib_grant == 0, "R6 single pulse", hib_grant, 0);
    tick(2); hib_req = 0; tick(1);

    // R7 veto while low
    wr(2'd0, 8'b0000_1001);
    cmp_low = 1; tick(8);
    hib_req = 1; tick(1);
    chk(hib_grant == 0, "R7 vetoed", hib_grant, 0);
    hib_req = 0; tick(1);
    wr(2'd0, 8'b0000_1000);
    hib_req = 1; tick(1);
    chk(hib_grant == 1, "R7 veto off grants", hib_grant, 1);
    hib_req = 0; tick(1);

    // R8 wake while hibernating
    wr(2'd0, 8'b0000_1010);
    hib_active = 1; tick(1);
    chk(wake_req == 1, "R8 wake", wake_req, 1);
    cmp_low = 0; tick(5);
    chk(wake_req == 1, "R8 wake held", wake_req, 1);
    hib_active = 0; tick(1);
    chk(wake_req == 0, "R8 wake release", wake_req, 0);
    hib_active = 1; tick(3);
    chk(wake_req == 0, "R8 no wake without low", wake_req, 0);
    hib_active = 0; tick(1);

    // random phase, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) cmp_low = ~cmp_low;
      hib_req = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 29) == 0) hib_active = ~hib_active;
      wr_en = ($urandom_range(0, 7) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom);
      tick(1);
    end
    wr_en = 0;
    tick(2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule